// File: doc/BRIEF.md
# I/O Load Return Formatter

This block builds the response beat for non-cacheable loads and instruction fetches served by an I/O device. It takes one request (access size code, a load/fetch selector, the byte offset inside the 16-byte field, the raw 16-byte device read data and two ECC status bits). It returns one 16-byte data field with a 2-bit error code and a 4-byte-fetch flag.

When the access is narrower than the field, the bytes of the addressed size-aligned lane are copied into every lane of the field. Instruction fetches always use 4 bytes and raise the fetch flag. Size codes that name no size give a zeroed field with the uncorrectable code.

A two-state controller handles flow. In `ST_IDLE` it offers `req_ready`. The transition *accept* (`req_valid` with `req_ready`) registers the formatted beat and moves to `ST_RESP`. In `ST_RESP` it holds `rsp_valid` and all response fields steady. The transition *deliver* (`rsp_ready`) returns it to `ST_IDLE`. Without `rsp_ready` it takes the self-loop *stall*.

Top module: `io_load_return_fmt`

## Requirements
- R1: The size code selects the access width for loads: 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes, 3 = 8 bytes, 4 = 16 bytes.
- R2: For an access of N bytes, output byte i (byte 0 in bits 7:0) equals raw byte (offset rounded down to a multiple of N) + (i mod N).
- R3: `rsp_err` is 2'b00 with no ECC flag, 2'b01 for a correctable error and 2'b10 for an uncorrectable one. When both ECC flags are set, it is 2'b10. The value 2'b11 never appears.
- R4: A fetch (`req_ifill`=1) ignores the size code, uses 4 bytes and sets `rsp_f4b`. A load leaves `rsp_f4b` clear.
- R5: A load with size code 5, 6 or 7 returns all-zero data with `rsp_err` = 2'b10, whatever the ECC flags are.
- R6: `req_ready` is low while a response is pending. A response not taken keeps `rsp_valid` and every response field unchanged.
- R7: After reset, `rsp_valid` is low and `req_ready` is high.
- R8: An accepted request shows `rsp_valid` high on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Formatter can take a request |
| req_size | input | 3 | Access size code |
| req_ifill | input | 1 | 1 = instruction fetch, 0 = load |
| req_offset | input | 4 | Byte offset within the 16-byte field |
| req_rdata | input | 128 | Raw device read data |
| req_ecc_corr | input | 1 | Correctable ECC error seen |
| req_ecc_uncorr | input | 1 | Uncorrectable ECC error seen |
| rsp_valid | output | 1 | Response beat present |
| rsp_ready | input | 1 | Consumer takes the beat |
| rsp_data | output | 128 | Replicated return data |
| rsp_err | output | 2 | Error code |
| rsp_f4b | output | 1 | 4-byte fetch flag |

## Verification
The bench sweeps every legal size at several unaligned offsets. A design that zero-extends instead of replicating, or that ignores the offset when picking the lane, shows wrong upper bytes. Fetches are sent with illegal and 16-byte size codes. A formatter that trusts the size for fetches then returns the wrong width or an error code. Both ECC flags set and illegal loads with a correctable flag test the error priority. A held `rsp_ready` low stalls responses and catches a design that drops or changes a beat.

// File: rtl/iolr_pkg.sv
package iolr_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RESP = 1'b1
    } iolr_state_t;

    typedef enum logic [1:0] {
        ERR_NONE   = 2'b00,
        ERR_CORR   = 2'b01,
        ERR_UNCORR = 2'b10
    } iolr_err_t;

    localparam int unsigned SIZE_CODE_W = 3;
    localparam logic [SIZE_CODE_W-1:0] FETCH_SIZE_CODE = 3'd2;

endpackage

// File: rtl/iolr_size_decode.sv
module iolr_size_decode
    import iolr_pkg::*;
#(
    parameter int unsigned MAX_LOG2 = 4
) (
    input  logic [SIZE_CODE_W-1:0] size_code,
    input  logic                   is_ifill,
    output logic [SIZE_CODE_W-1:0] eff_log2,
    output logic                   illegal,
    output logic                   fetch_flag
);

    always_comb begin
        fetch_flag = is_ifill;
        if (is_ifill) begin
            eff_log2 = FETCH_SIZE_CODE;
            illegal  = 1'b0;
        end else if (32'(size_code) > MAX_LOG2) begin
            eff_log2 = '0;
            illegal  = 1'b1;
        end else begin
            eff_log2 = size_code;
            illegal  = 1'b0;
        end
    end

endmodule

// File: rtl/iolr_lane_replicate.sv
module iolr_lane_replicate
    import iolr_pkg::*;
#(
    parameter int unsigned DATA_BYTES = 16,
    localparam int unsigned OFF_W     = $clog2(DATA_BYTES),
    localparam int unsigned DATA_W    = 8 * DATA_BYTES
) (
    input  logic [DATA_W-1:0]      raw,
    input  logic [OFF_W-1:0]       offset,
    input  logic [SIZE_CODE_W-1:0] log2_bytes,
    output logic [DATA_W-1:0]      replicated
);

    logic [OFF_W-1:0] lane_mask;
    logic [OFF_W-1:0] lane_base;

    always_comb begin
        lane_mask = OFF_W'((32'd1 << log2_bytes) - 32'd1);
        lane_base = offset & ~lane_mask;
    end

    for (genvar gi = 0; gi < DATA_BYTES; gi++) begin : g_byte
        logic [OFF_W-1:0] src_idx;
        always_comb begin
            src_idx = lane_base | (OFF_W'(gi) & lane_mask);
            replicated[8*gi +: 8] = raw[8*src_idx +: 8];
        end
    end

endmodule

// File: rtl/iolr_err_encode.sv
module iolr_err_encode
    import iolr_pkg::*;
(
    input  logic      ecc_corr,
    input  logic      ecc_uncorr,
    input  logic      size_illegal,
    output iolr_err_t err_code
);

    always_comb begin
        if (ecc_uncorr || size_illegal) begin
            err_code = ERR_UNCORR;
        end else if (ecc_corr) begin
            err_code = ERR_CORR;
        end else begin
            err_code = ERR_NONE;
        end
    end

endmodule

// File: rtl/io_load_return_fmt.sv
module io_load_return_fmt
    import iolr_pkg::*;
#(
    parameter int unsigned DATA_BYTES = 16,
    localparam int unsigned OFF_W     = $clog2(DATA_BYTES),
    localparam int unsigned DATA_W    = 8 * DATA_BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [2:0]        req_size,
    input  logic              req_ifill,
    input  logic [OFF_W-1:0]  req_offset,
    input  logic [DATA_W-1:0] req_rdata,
    input  logic              req_ecc_corr,
    input  logic              req_ecc_uncorr,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic [1:0]        rsp_err,
    output logic              rsp_f4b
);

    iolr_state_t state_q, state_d;

    logic [SIZE_CODE_W-1:0] eff_log2;
    logic                   size_illegal;
    logic                   fetch_flag;
    logic [DATA_W-1:0]      rep_data;
    iolr_err_t              err_code;

    logic [DATA_W-1:0] data_q;
    logic [1:0]        err_q;
    logic              f4b_q;
    logic              accept;

    iolr_size_decode #(
        .MAX_LOG2 (OFF_W)
    ) u_size (
        .size_code  (req_size),
        .is_ifill   (req_ifill),
        .eff_log2   (eff_log2),
        .illegal    (size_illegal),
        .fetch_flag (fetch_flag)
    );

    iolr_lane_replicate #(
        .DATA_BYTES (DATA_BYTES)
    ) u_rep (
        .raw        (req_rdata),
        .offset     (req_offset),
        .log2_bytes (eff_log2),
        .replicated (rep_data)
    );

    iolr_err_encode u_err (
        .ecc_corr     (req_ecc_corr),
        .ecc_uncorr   (req_ecc_uncorr),
        .size_illegal (size_illegal),
        .err_code     (err_code)
    );

    assign accept = req_valid && (state_q == ST_IDLE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: if (req_valid) state_d = ST_RESP;
            ST_RESP: if (rsp_ready) state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
            err_q  <= ERR_NONE;
            f4b_q  <= 1'b0;
        end else if (accept) begin
            data_q <= size_illegal ? '0 : rep_data;
            err_q  <= err_code;
            f4b_q  <= fetch_flag;
        end
    end

    always_comb begin
        req_ready = (state_q == ST_IDLE);
        rsp_valid = (state_q == ST_RESP);
        rsp_data  = data_q;
        rsp_err   = err_q;
        rsp_f4b   = f4b_q;
    end

endmodule

// File: rtl/iolr_checker.sv
module iolr_checker #(
    parameter int unsigned DATA_W = 128
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic [2:0]        req_size,
    input logic              req_ifill,
    input logic              rsp_valid,
    input logic              rsp_ready,
    input logic [DATA_W-1:0] rsp_data,
    input logic [1:0]        rsp_err,
    input logic              rsp_f4b
);

    p_busy_blocks_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !req_ready);

    p_hold_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data)
                                       && $stable(rsp_err) && $stable(rsp_f4b)));

    p_resp_next_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> rsp_valid);

    p_err_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (rsp_err != 2'b11));

    p_illegal_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !req_ifill && (req_size > 3'd4))
        |=> (rsp_err == 2'b10 && rsp_data == '0));

    p_fetch_flag_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> (rsp_f4b == $past(req_ifill)));

endmodule

bind io_load_return_fmt iolr_checker #(.DATA_W(DATA_W)) u_iolr_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .req_size  (req_size),
    .req_ifill (req_ifill),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rsp_err   (rsp_err),
    .rsp_f4b   (rsp_f4b)
);

// File: tb/io_load_return_fmt_bench.sv
module io_load_return_fmt_bench;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req_valid = 1'b0;
    logic         req_ready;
    logic [2:0]   req_size = '0;
    logic         req_ifill = 1'b0;
    logic [3:0]   req_offset = '0;
    logic [127:0] req_rdata = '0;
    logic         req_ecc_corr = 1'b0;
    logic         req_ecc_uncorr = 1'b0;
    logic         rsp_valid;
    logic         rsp_ready = 1'b0;
    logic [127:0] rsp_data;
    logic [1:0]   rsp_err;
    logic         rsp_f4b;

    typedef struct packed {
        logic [127:0] data;
        logic [1:0]   err;
        logic         f4b;
        logic [7:0]   tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    int   n_sent   = 0;
    int   n_seen   = 0;
    bit   stall_mode = 1'b0;
    int   cyc = 0;

    always #5 clk = ~clk;

    io_load_return_fmt u_io_load_return_fmt (
        .clk            (clk),
        .rst_n          (rst_n),
        .req_valid      (req_valid),
        .req_ready      (req_ready),
        .req_size       (req_size),
        .req_ifill      (req_ifill),
        .req_offset     (req_offset),
        .req_rdata      (req_rdata),
        .req_ecc_corr   (req_ecc_corr),
        .req_ecc_uncorr (req_ecc_uncorr),
        .rsp_valid      (rsp_valid),
        .rsp_ready      (rsp_ready),
        .rsp_data       (rsp_data),
        .rsp_err        (rsp_err),
        .rsp_f4b        (rsp_f4b)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic exp_t model(input logic [127:0] raw, input logic [3:0] off,
                                   input logic [2:0] code, input bit ifill,
                                   input bit corr, input bit uncorr);
        exp_t e;
        int   nb;
        int   base;
        e.tag = '0;
        e.f4b = ifill;
        if (!ifill && code > 3'd4) begin
            e.data = '0;
            e.err  = 2'b10;
        end else begin
            nb   = ifill ? 4 : (1 << code);
            base = int'(off) - (int'(off) % nb);
            for (int b = 0; b < 16; b++) begin
                e.data[8*b +: 8] = raw[8*(base + (b % nb)) +: 8];
            end
            e.err = uncorr ? 2'b10 : (corr ? 2'b01 : 2'b00);
        end
        return e;
    endfunction

    function automatic logic [127:0] make_raw(input int seed);
        logic [127:0] r;
        for (int k = 0; k < 16; k++) begin
            r[8*k +: 8] = 8'(k * 17 + seed * 29 + 3);
        end
        return r;
    endfunction

    task automatic send(input logic [2:0] code, input bit ifill, input logic [3:0] off,
                        input int seed, input bit corr, input bit uncorr,
                        input logic [7:0] tag);
        exp_t e;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid      = 1'b1;
        req_size       = code;
        req_ifill      = ifill;
        req_offset     = off;
        req_rdata      = make_raw(seed);
        req_ecc_corr   = corr;
        req_ecc_uncorr = uncorr;
        e     = model(make_raw(seed), off, code, ifill, corr, uncorr);
        e.tag = tag;
        exp_q.push_back(e);
        n_sent++;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // consumer ready pattern: stalls two of every three cycles in stall mode
    always @(posedge clk) begin
        cyc <= cyc + 1;
        #1 rsp_ready <= stall_mode ? ((cyc % 3) == 0) : 1'b1;
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid && rsp_ready) begin
            exp_t e;
            n_seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R6", "unexpected response", rsp_data, '0);
            end else begin
                e = exp_q.pop_front();
                check(rsp_data == e.data, "R1/R2", $sformatf("data tag %0d", e.tag),
                      rsp_data, e.data);
                check(rsp_err == e.err, "R3/R5", $sformatf("err tag %0d", e.tag),
                      128'(rsp_err), 128'(e.err));
                check(rsp_f4b == e.f4b, "R4", $sformatf("f4b tag %0d", e.tag),
                      128'(rsp_f4b), 128'(e.f4b));
            end
        end
    end

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                // R7: reset state
                check(rsp_valid == 1'b0, "R7", "rsp_valid in reset", 128'(rsp_valid), 0);
                check(req_ready == 1'b1, "R7", "req_ready in reset", 128'(req_ready), 1);
                rst_n = 1'b1;
                @(negedge clk);

                // R8: one-cycle latency
                @(negedge clk);
                req_valid = 1'b1; req_size = 3'd0; req_ifill = 1'b0; req_offset = 4'd5;
                req_rdata = make_raw(1); req_ecc_corr = 1'b0; req_ecc_uncorr = 1'b0;
                begin
                    exp_t e;
                    e = model(make_raw(1), 4'd5, 3'd0, 1'b0, 1'b0, 1'b0);
                    e.tag = 8'd0;
                    exp_q.push_back(e);
                    n_sent++;
                end
                @(negedge clk);
                req_valid = 1'b0;
                check(rsp_valid == 1'b1, "R8", "valid one cycle after accept",
                      128'(rsp_valid), 1);

                // R1, R2: every legal size at several offsets
                for (int c = 0; c < 5; c++) begin
                    for (int o = 0; o < 16; o += 5) begin
                        send(3'(c), 1'b0, 4'(o), c + o, 1'b0, 1'b0, 8'(10 + c * 4 + o / 5));
                    end
                end

                // R4: fetches ignore size, including illegal and 16-byte codes
                send(3'd7, 1'b1, 4'd9, 4, 1'b0, 1'b0, 8'd40);
                send(3'd4, 1'b1, 4'd14, 5, 1'b0, 1'b0, 8'd41);
                send(3'd0, 1'b1, 4'd3, 6, 1'b1, 1'b0, 8'd42);

                // R3: error encoding and priority
                send(3'd3, 1'b0, 4'd8, 7, 1'b1, 1'b0, 8'd50);
                send(3'd2, 1'b0, 4'd4, 8, 1'b0, 1'b1, 8'd51);
                send(3'd1, 1'b0, 4'd2, 9, 1'b1, 1'b1, 8'd52);

                // R5: illegal load sizes, with and without ECC flags
                send(3'd5, 1'b0, 4'd0, 10, 1'b0, 1'b0, 8'd60);
                send(3'd6, 1'b0, 4'd7, 11, 1'b1, 1'b0, 8'd61);
                send(3'd7, 1'b0, 4'd15, 12, 1'b0, 1'b0, 8'd62);

                // R6: stalled consumer; beats must be neither lost nor altered
                stall_mode = 1'b1;
                for (int s = 0; s < 6; s++) begin
                    send(3'(s % 5), s[0], 4'(s * 3), 20 + s, s[1], 1'b0, 8'(70 + s));
                end
                stall_mode = 1'b0;

                repeat (10) @(negedge clk);
                check(exp_q.size() == 0 && n_seen == n_sent, "R6", "all responses delivered",
                      128'(n_seen), 128'(n_sent));
            end
            begin
                repeat (20000) @(posedge clk);
                check(1'b0, "R8", "watchdog expired", 0, 1);
            end
        join_any
        disable fork;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule